// File: doc/BRIEF.md
# DDR2 Mode Register Write Sequencer

This block turns a structured configuration request into one DDR2 mode register write on the memory command bus. A requester presents burst length, burst ordering, CAS latency, DLL reset, write recovery and power-down exit speed. The block checks them, packs them into the row address bus and drives the command pins with the bank address set to zero. It takes a request only while the memory reports every bank precharged and clock enable high. Once the command has gone out, the block keeps the bus quiet for a programmable mode-register cycle time and then pulses `done`.

The request side uses valid/ready. `req_ready` is high only while the sequencer is idle. A request is consumed on any clock edge where `req_valid` and `req_ready` are both high, and the request fields must be stable in that cycle. While `req_ready` is low, the requester keeps `req_valid` and the fields unchanged; nothing is taken until `req_ready` returns. A refused request is also consumed. It produces a one-cycle `err` pulse and no command. `configured` stays low from reset until the first command is driven, because the memory register holds no defined value before that.

Top module: `ddr2_mrs_seq`

## Requirements
- R1: After reset the command bus shows a deselect (cs_n, ras_n, cas_n, we_n all 1), req_ready is 1, and done, err and configured are 0.
- R2: A legal request accepted at a clock edge drives, in the next cycle only, cs_n=ras_n=cas_n=we_n=0 with ba all zero.
- R3: During that command cycle the address bus carries burst length in bits 2:0, burst ordering in bit 3, CAS latency in bits 6:4, DLL reset in bit 8, write recovery in bits 11:9 and slow power-down exit in bit 12.
- R4: Address bit 7 (test mode) and every bit above 12 are 0 in every command.
- R5: A request accepted while banks_idle is 0 or cke is 0 raises err for exactly the next cycle and drives no command.
- R6: Burst length codes other than 3'b010 (4) and 3'b011 (8) are refused with an err pulse and no command.
- R7: CAS latency codes outside 2..6 and write recovery codes outside 1..5 are refused with an err pulse and no command.
- R8: With T = tmrd_cycles sampled at acceptance (0 treated as 1), if the command is in cycle c, then cycles c+1 .. c+T-1 show deselect with req_ready 0, and cycle c+T shows done=1 for one cycle with req_ready 1.
- R9: configured rises with the first command and stays 1; refused requests never set it.
- R10: A request held valid while req_ready is 0 is not consumed; it is taken at the first edge with req_ready high and its command follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_bl | input | 3 | Burst length code |
| req_bt | input | 1 | Burst ordering (0 sequential, 1 interleaved) |
| req_cl | input | 3 | CAS latency code |
| req_dll_rst | input | 1 | Request a DLL reset |
| req_wr | input | 3 | Write recovery code |
| req_pd_slow | input | 1 | 1 = slow power-down exit, 0 = fast exit |
| banks_idle | input | 1 | All banks precharged |
| cke | input | 1 | Clock enable currently high |
| tmrd_cycles | input | TMRD_W | Mode-register cycle time in clocks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| done | output | 1 | One-cycle pulse when the cycle time has elapsed |
| err | output | 1 | One-cycle pulse for a refused request |
| configured | output | 1 | A mode register write has been issued since reset |

## Verification
The bench aims at the edges of the wait window. It checks that a second request held against a low ready is issued exactly one cycle after done and not earlier. A design that drops ready one cycle late, or counts the command cycle twice, would show the second command at the wrong cycle. It also uses a zero cycle time, where a counter that is not clamped would wrap and stall for a full counter range. Refusal cases (bank not idle, clock enable low, bad burst length, CAS latency or write recovery) must each give err with the bus still deselected and configured left unchanged; a design that validated late would leak a command. Distinct field patterns, including all ones in the legal fields, expose packing that is swapped or shifted.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       dll_rst;
    logic [2:0] wr;
    logic       pd_slow;
  } mrs_cfg_t;

  localparam logic [2:0] BL_CODE_4  = 3'b010;
  localparam logic [2:0] BL_CODE_8  = 3'b011;
  localparam logic [2:0] CL_CODE_LO = 3'd2;
  localparam logic [2:0] CL_CODE_HI = 3'd6;
  localparam logic [2:0] WR_CODE_LO = 3'd1;
  localparam logic [2:0] WR_CODE_HI = 3'd5;
  localparam int         FIELD_BITS = 13;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_t;

endpackage

// File: rtl/mrs_field_pack.sv
module mrs_field_pack
  import ddr2_mrs_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  mrs_cfg_t          cfg,
  output logic              legal,
  output logic [ADDR_W-1:0] addr_word
);
  logic [FIELD_BITS-1:0] low_bits;
  logic bl_ok, cl_ok, wr_ok;

  always_comb begin
    bl_ok = (cfg.bl == BL_CODE_4) || (cfg.bl == BL_CODE_8);
    cl_ok = (cfg.cl >= CL_CODE_LO) && (cfg.cl <= CL_CODE_HI);
    wr_ok = (cfg.wr >= WR_CODE_LO) && (cfg.wr <= WR_CODE_HI);
    legal = bl_ok && cl_ok && wr_ok;
    // test-mode position is forced low
    low_bits = {cfg.pd_slow, cfg.wr, cfg.dll_rst, 1'b0, cfg.cl, cfg.bt, cfg.bl};
  end

  generate
    if (ADDR_W > FIELD_BITS) begin : g_pad
      assign addr_word = {{(ADDR_W-FIELD_BITS){1'b0}}, low_bits};
    end else begin : g_trim
      assign addr_word = low_bits[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mrs_cycle_timer.sv
module mrs_cycle_timer #(
  parameter int TMRD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TMRD_W-1:0] load_val,
  output logic              expire
);
  localparam logic [TMRD_W-1:0] ONE = TMRD_W'(1);
  logic [TMRD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= (load_val == '0) ? ONE : load_val;
    else if (cnt != '0)         cnt <= cnt - ONE;
  end

  assign expire = (cnt == ONE);

  a_r8_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt != '0));
  a_r8_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/ddr2_mrs_seq.sv
module ddr2_mrs_seq
  import ddr2_mrs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int TMRD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_bl,
  input  logic              req_bt,
  input  logic [2:0]        req_cl,
  input  logic              req_dll_rst,
  input  logic [2:0]        req_wr,
  input  logic              req_pd_slow,
  input  logic              banks_idle,
  input  logic              cke,
  input  logic [TMRD_W-1:0] tmrd_cycles,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              err,
  output logic              configured
);
  seq_state_t        st;
  mrs_cfg_t          cfg;
  logic              legal, expire, take, go;
  logic [ADDR_W-1:0] packed_addr;

  assign cfg = '{bl: req_bl, bt: req_bt, cl: req_cl, dll_rst: req_dll_rst,
                 wr: req_wr, pd_slow: req_pd_slow};

  mrs_field_pack #(.ADDR_W(ADDR_W)) u_pack (
    .cfg(cfg), .legal(legal), .addr_word(packed_addr));

  assign req_ready = (st == SEQ_IDLE);
  assign take      = req_valid && req_ready;
  assign go        = take && legal && banks_idle && cke;

  mrs_cycle_timer #(.TMRD_W(TMRD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(tmrd_cycles),
    .expire(expire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SEQ_IDLE;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba <= '0; addr <= '0;
      done <= 1'b0; err <= 1'b0; configured <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba <= '0; addr <= '0;
      done <= 1'b0; err <= 1'b0;
      case (st)
        SEQ_IDLE: if (take) begin
          if (go) begin
            st <= SEQ_BUSY;
            {cs_n, ras_n, cas_n, we_n} <= 4'b0000;
            addr <= packed_addr;
            configured <= 1'b1;
          end else begin
            err <= 1'b1;
          end
        end
        SEQ_BUSY: if (expire) begin
          st   <= SEQ_IDLE;
          done <= 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  a_r5_issue_needs_precond: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req_valid && banks_idle && cke));
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
  a_r6_bl_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (addr[2:1] == 2'b01));
  a_r5_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !done));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured);
endmodule

// File: tb/sim_ddr2_mrs_seq.sv
`timescale 1ns/1ps
module sim_ddr2_mrs_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_bl = 3'b010, req_cl = 3'd3, req_wr = 3'd2;
  logic req_bt = 1'b0, req_dll_rst = 1'b0, req_pd_slow = 1'b0;
  logic banks_idle = 1'b1, cke = 1'b1;
  logic [3:0] tmrd_cycles = 4'd2;
  logic cs_n, ras_n, cas_n, we_n, done, err, configured;
  logic [2:0] ba;
  logic [13:0] addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ddr2_mrs_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] exp_addr(logic [2:0] bl, logic bt, logic [2:0] cl,
                                           logic dll, logic [2:0] wr, logic pd);
    return {1'b0, pd, wr, dll, 1'b0, cl, bt, bl};
  endfunction

  task automatic set_req(logic [2:0] bl, logic bt, logic [2:0] cl, logic dll,
                         logic [2:0] wr, logic pd, logic [3:0] t);
    req_bl = bl; req_bt = bt; req_cl = cl; req_dll_rst = dll;
    req_wr = wr; req_pd_slow = pd; tmrd_cycles = t; req_valid = 1'b1;
  endtask

  // legal request: checks command cycle, wait window, done
  task automatic t_legal(logic [2:0] bl, logic bt, logic [2:0] cl, logic dll,
                         logic [2:0] wr, logic pd, logic [3:0] t);
    int te;
    te = (t == 0) ? 1 : t;
    @(negedge clk); set_req(bl, bt, cl, dll, wr, pd, t);
    @(negedge clk); req_valid = 1'b0;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0000, "R2 cmd pins", {cs_n, ras_n, cas_n, we_n}, 0);
    chk(ba == 3'b000, "R2 bank zero", ba, 0);
    chk(addr == exp_addr(bl, bt, cl, dll, wr, pd), "R3 packing", addr, exp_addr(bl, bt, cl, dll, wr, pd));
    chk(addr[7] == 1'b0 && addr[13] == 1'b0, "R4 test/high bits", addr, 0);
    chk(configured == 1'b1, "R9 configured set", configured, 1);
    for (int i = 1; i < te; i++) begin
      @(negedge clk);
      chk(cs_n && !req_ready && !done, "R8 wait window", {cs_n, req_ready, done}, 3'b100);
    end
    @(negedge clk);
    chk(done && req_ready && cs_n, "R8 done at c+T", {done, req_ready, cs_n}, 3'b111);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic t_refuse(logic [2:0] bl, logic [2:0] cl, logic [2:0] wr,
                          logic idle, logic ck, string req);
    logic cfg_before;
    cfg_before = configured;
    @(negedge clk); banks_idle = idle; cke = ck; set_req(bl, 1'b0, cl, 1'b0, wr, 1'b0, 4'd2);
    @(negedge clk); req_valid = 1'b0; banks_idle = 1'b1; cke = 1'b1;
    chk(err && cs_n, {req, " err without cmd"}, {err, cs_n}, 2'b11);
    chk(configured == cfg_before, {req, " configured unchanged"}, configured, cfg_before);
    @(negedge clk);
    chk(!err && cs_n && req_ready, {req, " err one cycle"}, {err, cs_n, req_ready}, 3'b011);
  endtask

  // R10: second request held while busy
  task automatic t_backpressure();
    @(negedge clk); set_req(3'b011, 1'b1, 3'd4, 1'b0, 3'd3, 1'b0, 4'd4);
    @(negedge clk);
    chk(!cs_n, "R10 first cmd", cs_n, 0);
    set_req(3'b010, 1'b0, 3'd5, 1'b1, 3'd4, 1'b1, 4'd4);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk(cs_n && !req_ready, "R10 held not consumed", {cs_n, req_ready}, 2'b10);
    end
    @(negedge clk);
    chk(done && req_ready && cs_n, "R10 ready returns", {done, req_ready, cs_n}, 3'b111);
    @(negedge clk); req_valid = 1'b0;
    chk(!cs_n && addr == exp_addr(3'b010, 1'b0, 3'd5, 1'b1, 3'd4, 1'b1), "R10 second cmd",
        addr, exp_addr(3'b010, 1'b0, 3'd5, 1'b1, 3'd4, 1'b1));
    repeat (5) @(negedge clk);
    chk(req_ready && cs_n, "R10 back to idle", {req_ready, cs_n}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 deselect", {cs_n, ras_n, cas_n, we_n}, 4'hf);
    chk(req_ready && !done && !err && !configured, "R1 flags",
        {req_ready, done, err, configured}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    t_refuse(3'b010, 3'd3, 3'd2, 1'b0, 1'b1, "R5 banks busy");
    t_refuse(3'b010, 3'd3, 3'd2, 1'b1, 1'b0, "R5 cke low");
    t_refuse(3'b001, 3'd3, 3'd2, 1'b1, 1'b1, "R6 bl 2");
    t_refuse(3'b110, 3'd3, 3'd2, 1'b1, 1'b1, "R6 bl 6");
    chk(!configured, "R9 not set by refusals", configured, 0);
    t_legal(3'b010, 1'b0, 3'd3, 1'b0, 3'd2, 1'b0, 4'd2);
    t_legal(3'b011, 1'b1, 3'd6, 1'b1, 3'd5, 1'b1, 4'd3);
    t_legal(3'b010, 1'b1, 3'd2, 1'b0, 3'd1, 1'b1, 4'd0);
    t_legal(3'b011, 1'b0, 3'd5, 1'b1, 3'd4, 1'b0, 4'd7);
    t_refuse(3'b010, 3'd7, 3'd2, 1'b1, 1'b1, "R7 cl 7");
    t_refuse(3'b010, 3'd1, 3'd2, 1'b1, 1'b1, "R7 cl 1");
    t_refuse(3'b011, 3'd4, 3'd0, 1'b1, 1'b1, "R7 wr 0");
    t_refuse(3'b011, 3'd4, 3'd6, 1'b1, 1'b1, "R7 wr 6");
    chk(configured, "R9 stays set", configured, 1);
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule